// File: doc/BRIEF.md
# Binary-Field Montgomery Squarer

This block squares an element of the binary field GF(2^m) and returns the result in Montgomery form, A^2 · x^-R mod P. The reduction polynomial P is an input, so one instance can serve any field of degree m. Coefficients are added with XOR and there are no carries. Because of this, the unreduced square needs no partial products. Each operand bit a_i becomes coefficient 2i of a 2m-1 bit vector, and the odd positions are zero.

The wide square is then reduced with word-level Montgomery reduction. Each word step forms a factor q from the low w bits of the running value and a precomputed inverse of the low word of P. The step adds q·P, which clears those w bits, and shifts right by w. Two such steps are chained in one clock. The word count is rounded up to an even number, so R = 2·ceil(m/2w)·w and the reduction takes ceil(m/2w) cycles. After R shifts the value has degree below m, so no final subtraction is needed.

To use the block, the caller pulses start with the operand, the polynomial and the low-word inverse. It then waits for the one-cycle done pulse and reads the result.

Top module: `gf2MontSquarer`

## Requirements
- R1: For an operand of degree below m, and for P with coefficients m and 0 set, the result equals A^2 · x^-R mod P, where R = 2·ceil(m/(2w))·w. The result has degree below m and needs no further reduction.
- R2: If start is high at a rising edge while busy is low, done is high for the cycle after the edge that comes ceil(m/(2w)) edges later.
- R3: done is high for exactly one cycle per accepted start.
- R4: start, opA, poly and polyInv are sampled only at the accepted start edge. While busy is high, changes on them and further start pulses have no effect on the result, and they produce no extra done pulse.
- R5: result changes only at the edge where done rises, and holds its value until the next completion.
- R6: While rstN is low, and after it is released, busy and done are low and result is zero.
- R7: busy is high from the edge after an accepted start until done rises, and done and busy are never high together.
- R8: polyInv must equal the inverse of (P mod x^w) modulo x^w, computed by carry-less product. The block uses it for every word step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a squaring when idle |
| opA | input | M | Operand, bit i is the coefficient of x^i |
| poly | input | M+1 | Reduction polynomial, bits M and 0 set |
| polyInv | input | W | Inverse of the low word of poly modulo x^W |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | M | A^2 · x^-R mod P, held until next completion |

## Verification
The directed operands are zero, one, all ones and the single top coefficient. Zero must stay zero. One exposes the pure x^-R factor. All ones fills every even square position. The top coefficient drives the highest square term, which requires the most reduction. Random operands run under two fixed trinomials and under random polynomials with both end coefficients set, and polyInv is recomputed for each one. This separates errors in the q factor from errors in the shift. One case changes the inputs and pulses start again in mid-run. It shows whether the captured copies are the ones actually used, and whether a second completion is wrongly triggered.

// File: rtl/gf2msq_pkg.sv
package gf2msq_pkg;
  typedef struct packed {
    logic load;    // capture operand, polynomial and inverse
    logic step;    // advance the accumulator by two word steps
    logic finish;  // last double step: latch the result
  } msqCtl_t;
endpackage

// File: rtl/gf2msqWordStep.sv
module gf2msqWordStep #(
  parameter int M  = 17,
  parameter int W  = 4,
  parameter int AW = 33
) (
  input  logic [AW-1:0] tIn,
  input  logic [M:0]    poly,
  input  logic [W-1:0]  pinv,
  output logic [AW-1:0] tOut
);
  logic [W-1:0]  qFac;
  logic [AW-1:0] qProd;
  logic [AW-1:0] sumV;

  // qFac = low word of tIn times pinv, carry-less, modulo x^W
  always_comb begin
    qFac = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j <= i; j++) begin
        qFac[i] = qFac[i] ^ (tIn[j] & pinv[i-j]);
      end
    end
  end

  // qProd = qFac * poly, carry-less
  always_comb begin
    qProd = '0;
    for (int j = 0; j < W; j++) begin
      if (qFac[j]) qProd = qProd ^ ({{(AW-M-1){1'b0}}, poly} << j);
    end
  end

  assign sumV = tIn ^ qProd;
  assign tOut = sumV >> W;
endmodule

// File: rtl/gf2msqDatapath.sv
module gf2msqDatapath
  import gf2msq_pkg::*;
#(
  parameter int M  = 17,
  parameter int W  = 4,
  parameter int AW = 33
) (
  input  logic         clk,
  input  logic         rstN,
  input  msqCtl_t      ctl,
  input  logic [M-1:0] opA,
  input  logic [M:0]   poly,
  input  logic [W-1:0] polyInv,
  output logic [M-1:0] result
);
  localparam int STEPS = 2;

  logic [AW-1:0] spreadVal;
  logic [AW-1:0] accQ;
  logic [M:0]    polyQ;
  logic [W-1:0]  pinvQ;
  logic [M-1:0]  resultQ;
  logic [AW-1:0] chain [0:STEPS];

  // square by zero interleave
  always_comb begin
    spreadVal = '0;
    for (int i = 0; i < M; i++) spreadVal[2*i] = opA[i];
  end

  assign chain[0] = accQ;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    gf2msqWordStep #(.M(M), .W(W), .AW(AW)) u_step (
      .tIn  (chain[s]),
      .poly (polyQ),
      .pinv (pinvQ),
      .tOut (chain[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      polyQ   <= '0;
      pinvQ   <= '0;
      resultQ <= '0;
    end else if (ctl.load) begin
      accQ  <= spreadVal;
      polyQ <= poly;
      pinvQ <= polyInv;
    end else if (ctl.step) begin
      accQ <= chain[STEPS];
      if (ctl.finish) resultQ <= chain[STEPS][M-1:0];
    end
  end

  assign result = resultQ;
endmodule

// File: rtl/gf2msqControl.sv
module gf2msqControl
  import gf2msq_pkg::*;
#(
  parameter int CYC = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output msqCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic          busyQ;
  logic          doneQ;
  logic [CW-1:0] cntQ;

  always_comb begin
    ctl        = '0;
    ctl.load   = start && !busyQ;
    ctl.step   = busyQ;
    ctl.finish = busyQ && (cntQ == CW'(CYC-1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= ctl.finish;
      if (ctl.load) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (ctl.finish) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/gf2MontSquarer.sv
module gf2MontSquarer
  import gf2msq_pkg::*;
#(
  parameter int M = 17,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [M-1:0] opA,
  input  logic [M:0]   poly,
  input  logic [W-1:0] polyInv,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] result
);
  localparam int CYC = (M + 2*W - 1) / (2*W);
  localparam int AW  = (2*M - 1 > M + W) ? 2*M - 1 : M + W;

  msqCtl_t ctl;

  gf2msqControl #(.CYC(CYC)) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  gf2msqDatapath #(.M(M), .W(W), .AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .poly    (poly),
    .polyInv (polyInv),
    .result  (result)
  );
endmodule

// File: rtl/gf2MontSquarer_chk.sv
module gf2MontSquarer_chk #(
  parameter int M = 17,
  parameter int W = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [M-1:0] result
);
  localparam int CYC = (M + 2*W - 1) / (2*W);

  int latCnt;

  always_ff @(posedge clk) begin
    if (!rstN)               latCnt <= 0;
    else if (start && !busy) latCnt <= 0;
    else if (busy)           latCnt <= latCnt + 1;
  end

  // R2
  latency_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == CYC));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
endmodule

bind gf2MontSquarer gf2MontSquarer_chk #(.M(M), .W(W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/gf2MontSquarer_bench.sv
module gf2MontSquarer_bench;
  localparam int M   = 17;
  localparam int W   = 4;
  localparam int CYC = (M + 2*W - 1) / (2*W);
  localparam int RB  = 2 * CYC * W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [M-1:0] opA = '0;
  logic [M:0]   poly = '0;
  logic [W-1:0] polyInv = '0;
  logic         busy, done;
  logic [M-1:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gf2MontSquarer #(.M(M), .W(W)) u_gf2MontSquarer (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .poly(poly),
    .polyInv(polyInv), .busy(busy), .done(done), .result(result)
  );

  // bit-serial reference: square, then R single-bit Montgomery steps
  function automatic logic [M-1:0] refMont(logic [M-1:0] a, logic [M:0] p);
    logic [2*M:0] t;
    t = '0;
    for (int i = 0; i < M; i++) t[2*i] = a[i];
    for (int k = 0; k < RB; k++) begin
      if (t[0]) t = t ^ {{M{1'b0}}, p};
      t = t >> 1;
    end
    return t[M-1:0];
  endfunction

  function automatic logic [W-1:0] invLow(logic [W-1:0] p0);
    for (int c = 0; c < (1 << W); c++) begin
      logic [W-1:0] cand, pr;
      cand = W'(c);
      pr = '0;
      for (int i = 0; i < W; i++)
        for (int j = 0; j <= i; j++) pr[i] = pr[i] ^ (p0[j] & cand[i-j]);
      if (pr == W'(1)) return cand;
    end
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [M-1:0] a, input logic [M:0] p);
    int lat;
    logic [M-1:0] exp, held;
    exp = refMont(a, p);
    @(negedge clk);
    opA = a; poly = p; polyInv = invLow(p[W-1:0]); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opA = ~a;  // R4: operand changes after capture must not matter
    check(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check(lat == CYC + 1, "R2 latency", 64'(lat - 1), 64'(CYC));
    check(result == exp, "R1 result", 64'(result), 64'(exp));
    check(busy == 1'b0, "R7 busy low at done", 64'(busy), 64'd0);
    held = result;
    @(negedge clk);
    check(done == 1'b0, "R3 single pulse", 64'(done), 64'd0);
    check(result == held, "R5 result held", 64'(result), 64'(held));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [M:0] pA, pB, pr;
    logic [M-1:0] a1, exp1, held;
    int seenDone;
    void'($urandom(32'h5eed_0017));
    pA = (M+1)'(1) << M | (M+1)'(9);     // x^17 + x^3 + 1
    pB = (M+1)'(1) << M | (M+1)'(65);    // x^17 + x^6 + 1

    repeat (3) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6 reset flags", {62'd0, busy, done}, 64'd0);
    check(result == '0, "R6 reset result", 64'(result), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0 && result == '0, "R6 after release",
          64'(result), 64'd0);

    // directed corners, R1 and R8 with the recomputed inverse
    runOp('0, pA);
    runOp(M'(1), pA);
    runOp('1, pA);
    runOp(M'(1) << (M-1), pB);
    runOp('1, pB);

    // random operands under fixed and random polynomials
    for (int n = 0; n < 40; n++) begin
      pr = {1'b1, (M-1)'($urandom), 1'b1};
      if (n % 3 == 0) runOp(M'($urandom), pA);
      else if (n % 3 == 1) runOp(M'($urandom), pB);
      else runOp(M'($urandom), pr);
    end

    // R4: restart and input changes while busy are ignored
    a1 = M'($urandom);
    exp1 = refMont(a1, pB);
    @(negedge clk);
    opA = a1; poly = pB; polyInv = invLow(pB[W-1:0]); start = 1'b1;
    @(negedge clk);
    opA = ~a1; poly = pA; polyInv = ~polyInv;
    @(negedge clk);
    start = 1'b0;
    seenDone = 0;
    for (int c = 0; c < CYC + 4; c++) begin
      if (done) begin
        seenDone++;
        held = result;
        check(result == exp1, "R4 result unaffected", 64'(result), 64'(exp1));
      end
      @(negedge clk);
    end
    check(seenDone == 1, "R4 no extra done", 64'(seenDone), 64'd1);
    check(result == held, "R5 held after idle", 64'(result), 64'(held));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule